// File: doc/BRIEF.md
# Debug Memory Access Engine

This block is a bus master that sits on the debug side of a chip. An external tool uses it to read or write target memory while the processor keeps running. Addresses go onto the memory port exactly as the tool wrote them. No translation stage and no cache sits in the path. The tool sees three registers: a start address, a data word, and a control/status word. It programs them in that order. The write to the control/status word launches the operation.

The control/status word selects an access size (byte, halfword, word), a direction (load from memory or store to memory) and a word count. The engine moves one item per step over a request/acknowledge memory port. After each step it advances the address by the access size and decrements the count. Between steps it raises a ready output, which is mirrored in a status bit. For loads, ready means the data register holds a fresh item that the tool can collect. For stores, ready means the data register can take the next item. A bus error stops the sequence and leaves an error flag set.

The state machine has four states:
- `ST_IDLE`: waits for a start.
- `ST_BUS`: a memory request is outstanding.
- `ST_HOLD`: a loaded item waits for the tool to read it.
- `ST_WAIT`: a store sequence waits for the next data word.

The transitions are:
- IDLE→BUS: a start with a legal size and a non-zero count.
- BUS→HOLD: a load is acknowledged.
- BUS→WAIT: a store is acknowledged and more items remain.
- BUS→IDLE: the last store is acknowledged, or the bus reports an error.
- HOLD→BUS: the data register is read and more items remain.
- HOLD→IDLE: the data register is read and it was the last item.
- WAIT→BUS: the data register is written.

Top module: `dbg_mem_access`

## Requirements
- R1: After reset the engine is idle. `mem_req` and `xfer_ready` are low, and the control/status register reads as zero.
- R2: Register select 0 is the start address, 1 is the data register and 2 is control/status. The control/status fields are:
  - bits [1:0]: size.
  - bit 2: direction, 1 = store.
  - bits [15:8]: remaining count.
  - bit 16: ready.
  - bit 17: error.
  - bit 18: busy.
  - All other bits read zero.
- R3: A control/status write in idle with a legal size and a non-zero count raises `mem_req` in the next cycle. `mem_addr` equals the address register, and `mem_size`/`mem_we` follow the written fields. The request stays high with a stable address until `mem_ack` or `mem_err`.
- R4: Size code 11 sets the error bit, leaves busy low, and issues no memory request.
- R5: Each completed step adds 1, 2 or 4 (for size 00, 01, 10) to the address register and subtracts one from the remaining count.
- R6: On a load acknowledge, the data register takes the size-wide low part of `mem_rdata`, zero-extended, and ready rises. Reading the data register (`reg_re` with select 1) lowers ready and launches the next load.
- R7: On a store acknowledge with items remaining, ready rises. Writing the data register lowers ready and launches the next store of that data.
- R8: When the count reaches zero, busy falls and ready stays high until the next control/status write. Status bit 16 always equals `xfer_ready`.
- R9: `mem_err` on an outstanding request ends the sequence. The error bit is set, and busy and ready are low.
- R10: While busy, writes to the address register and the control/status register are ignored.
- R11: A start with count zero issues no request. It completes at once, with ready high and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Tool register write strobe |
| reg_re | input | 1 | Tool register read strobe (consumes data on select 1) |
| reg_addr | input | 2 | Tool register select |
| reg_wdata | input | DW | Tool register write data |
| reg_rdata | output | DW | Selected register contents |
| xfer_ready | output | 1 | Per-item ready / completion |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a store |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW | Physical address |
| mem_wdata | output | DW | Store data, right-aligned |
| mem_rdata | input | DW | Load data, right-aligned |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed |

## Verification
The timing rules the checks follow are:
- A register write sampled at edge k is visible on `reg_rdata` and on the memory port after edge k.
- The request therefore appears one cycle after the control/status write.
- An acknowledge or error sampled at edge k moves ready, busy and the address after that same edge.
- A data-register access sampled at edge k relaunches `mem_req` after edge k.

The bench keeps its own per-cycle model and advances it at each rising edge from the same inputs. It compares `mem_req`, the request fields, `xfer_ready` and `reg_rdata` a quarter period after every edge, so each result is checked in exactly the cycle it is due. Scenario checks on the memory contents and the register readback are made only after ready, or a fixed settling wait, has passed.

// File: rtl/dbga_pkg.sv
package dbga_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_HOLD,
        ST_WAIT
    } state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CSR  = 2'd2;

    localparam int DIR_BIT   = 2;
    localparam int CNT_LSB   = 8;
    localparam int CNT_SPAN  = 8;
    localparam int RDY_BIT   = 16;
    localparam int ERR_BIT   = 17;
    localparam int BUSY_BIT  = 18;

endpackage

// File: rtl/dbga_addr_gen.sv
module dbga_addr_gen
    import dbga_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  size_e         size,
    output logic [AW-1:0] addr_q
);

    logic [AW-1:0] step;

    always_comb begin
        step = '0;
        unique case (size)
            SZ_BYTE: step = AW'(1);
            SZ_HALF: step = AW'(2);
            SZ_WORD: step = AW'(4);
            SZ_BAD:  step = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (adv) begin
            addr_q <= addr_q + step;
        end
    end

endmodule

// File: rtl/dbga_counter.sv
module dbga_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt_q,
    output logic          last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/dbga_lane_mask.sv
module dbga_lane_mask
    import dbga_pkg::*;
#(
    parameter int DW = 32
) (
    input  size_e         size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_comb begin
        dout = din;
        unique case (size)
            SZ_BYTE: dout = {{(DW-8){1'b0}},  din[7:0]};
            SZ_HALF: dout = {{(DW-16){1'b0}}, din[15:0]};
            SZ_WORD: dout = {{(DW-32){1'b0}}, din[31:0]};
            SZ_BAD:  dout = '0;
        endcase
    end

endmodule

// File: rtl/dbg_mem_access.sv
module dbg_mem_access
    import dbga_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          xfer_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err
);

    localparam int CNT_USE = (CW < CNT_SPAN) ? CW : CNT_SPAN;

    state_e        state_q, state_d;
    size_e         size_q;
    logic          dir_q;
    logic          err_q;
    logic          done_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          cnt_last;
    logic [DW-1:0] rd_masked;
    logic          busy;

    logic          addr_wr, data_wr, csr_wr, data_rd;
    logic          start, start_bad, start_zero;
    logic          bus_ok, bus_fail, step_done;
    size_e         size_in;
    logic [CW-1:0] cnt_in;

    assign addr_wr    = reg_we && (reg_addr == SEL_ADDR);
    assign data_wr    = reg_we && (reg_addr == SEL_DATA);
    assign csr_wr     = reg_we && (reg_addr == SEL_CSR);
    assign data_rd    = reg_re && (reg_addr == SEL_DATA);

    assign size_in    = size_e'(reg_wdata[1:0]);
    assign cnt_in     = CW'(reg_wdata[CNT_LSB +: CNT_USE]);
    assign start      = (state_q == ST_IDLE) && csr_wr;
    assign start_bad  = (size_in == SZ_BAD);
    assign start_zero = (cnt_in == '0);

    assign bus_fail   = (state_q == ST_BUS) && mem_err;
    assign bus_ok     = (state_q == ST_BUS) && mem_ack && !mem_err;
    assign step_done  = (bus_ok && dir_q) || ((state_q == ST_HOLD) && data_rd);

    dbga_addr_gen #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_wr && (state_q == ST_IDLE)),
        .load_val (AW'(reg_wdata)),
        .adv      (step_done),
        .size     (size_q),
        .addr_q   (addr_q)
    );

    dbga_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (cnt_in),
        .dec      (step_done),
        .cnt_q    (cnt_q),
        .last     (cnt_last)
    );

    dbga_lane_mask #(.DW(DW)) u_mask (
        .size (size_q),
        .din  (mem_rdata),
        .dout (rd_masked)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !start_bad && !start_zero) begin
                    state_d = ST_BUS;
                end
            end
            ST_BUS: begin
                if (mem_err) begin
                    state_d = ST_IDLE;
                end else if (mem_ack) begin
                    if (!dir_q) begin
                        state_d = ST_HOLD;
                    end else if (cnt_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_HOLD: begin
                if (data_rd) begin
                    state_d = cnt_last ? ST_IDLE : ST_BUS;
                end
            end
            ST_WAIT: begin
                if (data_wr) begin
                    state_d = ST_BUS;
                end
            end
        endcase
    end

    // transfer attributes, flags and data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= SZ_BYTE;
            dir_q  <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (start) begin
                size_q <= size_in;
                dir_q  <= reg_wdata[DIR_BIT];
                err_q  <= start_bad;
                done_q <= !start_bad && start_zero;
            end else if (bus_fail) begin
                err_q  <= 1'b1;
            end else if (step_done && cnt_last) begin
                done_q <= 1'b1;
            end

            if (bus_ok && !dir_q) begin
                data_q <= rd_masked;
            end else if (data_wr && ((state_q == ST_IDLE) || (state_q == ST_WAIT))) begin
                data_q <= reg_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        xfer_ready = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy       = 1'b0;
                xfer_ready = done_q;
            end
            ST_BUS:  mem_req    = 1'b1;
            ST_HOLD: xfer_ready = 1'b1;
            ST_WAIT: xfer_ready = 1'b1;
        endcase
    end

    assign mem_we    = dir_q;
    assign mem_size  = size_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = data_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_ADDR: reg_rdata = DW'(addr_q);
            SEL_DATA: reg_rdata = data_q;
            SEL_CSR: begin
                reg_rdata[1:0]                = size_q;
                reg_rdata[DIR_BIT]            = dir_q;
                reg_rdata[CNT_LSB +: CNT_USE] = cnt_q[CNT_USE-1:0];
                reg_rdata[RDY_BIT]            = xfer_ready;
                reg_rdata[ERR_BIT]            = err_q;
                reg_rdata[BUSY_BIT]           = busy;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbga_checker.sv
module dbga_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          xfer_ready,
    input logic          busy
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

    // R9
    err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (!mem_req && !xfer_ready && !busy));

    // R4
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd2 && reg_wdata[1:0] == 2'b11)
        |=> (!mem_req && !busy));

    // R8
    status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> (reg_rdata[16] == xfer_ready));

    // R6
    req_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !xfer_ready);

endmodule

bind dbg_mem_access dbga_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_addr   (mem_addr),
    .xfer_ready (xfer_ready),
    .busy       (busy)
);

// File: tb/tb_dbg_mem_access.sv
module tb_dbg_mem_access;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]    reg_addr = 2'd2;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          xfer_ready, mem_req, mem_we;
    logic [1:0]    mem_size;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0, mem_err = 1'b0;

    dbg_mem_access #(.AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_ready(xfer_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory responder ----------------
    logic [31:0] mem_arr [64];
    int lat = 0;
    int wcnt = 0;
    int txn_no = 0;
    int err_serial = -1;

    always @(negedge clk) begin
        if (mem_ack || mem_err) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                if (txn_no == err_serial) begin
                    mem_err = 1'b1;
                end else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        for (int k = 0; k < (1 << mem_size); k++)
                            mem_arr[mem_addr[7:2]][8*(mem_addr[1:0]+k) +: 8] = mem_wdata[8*k +: 8];
                    end else begin
                        mem_rdata = mem_arr[mem_addr[7:2]] >> (8*mem_addr[1:0]);
                    end
                end
                txn_no++;
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- reference model ----------------
    int          ph;          // 0 idle, 1 bus, 2 hold, 3 wait
    bit          m_done, m_err, m_dir;
    int          m_size, m_cnt;
    logic [31:0] m_addr, m_data;

    function automatic logic [31:0] keep_low(logic [31:0] v, int sz);
        longint lim = longint'(1) << (8 << sz);
        return 32'(longint'(v) % lim);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_done = 0; m_err = 0; m_dir = 0; m_size = 0; m_cnt = 0;
            m_addr = 0; m_data = 0;
        end else begin
            case (ph)
                0: begin
                    if (reg_we && reg_addr == 0) m_addr = reg_wdata;
                    if (reg_we && reg_addr == 1) m_data = reg_wdata;
                    if (reg_we && reg_addr == 2) begin
                        m_size = reg_wdata[1:0];
                        m_dir  = reg_wdata[2];
                        m_cnt  = reg_wdata[15:8];
                        m_err  = (m_size == 3);
                        m_done = (m_size != 3) && (m_cnt == 0);
                        if (m_size != 3 && m_cnt != 0) ph = 1;
                    end
                end
                1: begin
                    if (mem_err) begin
                        m_err = 1; ph = 0;
                    end else if (mem_ack) begin
                        if (!m_dir) begin
                            m_data = keep_low(mem_rdata, m_size);
                            ph = 2;
                        end else begin
                            m_cnt--; m_addr += (1 << m_size);
                            if (m_cnt == 0) begin m_done = 1; ph = 0; end
                            else ph = 3;
                        end
                    end
                end
                2: begin
                    if (reg_re && reg_addr == 1) begin
                        m_cnt--; m_addr += (1 << m_size);
                        if (m_cnt == 0) begin m_done = 1; ph = 0; end
                        else ph = 1;
                    end
                end
                default: begin
                    if (reg_we && reg_addr == 1) begin m_data = reg_wdata; ph = 1; end
                end
            endcase
        end
    end

    function automatic logic [31:0] model_view(logic [1:0] sel);
        logic rdy = (ph == 2) || (ph == 3) || (ph == 0 && m_done);
        case (sel)
            2'd0: return m_addr;
            2'd1: return m_data;
            2'd2: return {13'b0, (ph != 0), m_err, rdy, 8'(m_cnt), 5'b0, m_dir, 2'(m_size)};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            logic rdy_m;
            rdy_m = (ph == 2) || (ph == 3) || (ph == 0 && m_done);
            chk(mem_req == (ph == 1), "R3", "model mem_req", mem_req, (ph == 1));
            if (ph == 1) begin
                chk(mem_addr == m_addr, "R3", "model mem_addr", mem_addr, m_addr);
                chk(mem_we == m_dir, "R3", "model mem_we", mem_we, m_dir);
                chk(mem_size == 2'(m_size), "R3", "model mem_size", mem_size, m_size);
            end
            chk(xfer_ready == rdy_m, "R8", "model xfer_ready", xfer_ready, rdy_m);
            chk(reg_rdata == model_view(reg_addr), "R2", "model reg_rdata",
                reg_rdata, model_view(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic rd_data(output logic [31:0] v);
        @(negedge clk);
        reg_addr = 2'd1; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_addr = 2'd2;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!xfer_ready && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [31:0] csr(int sz, int dir, int cnt);
        return 32'((cnt << 8) | (dir << 2) | sz);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem_arr[i] = 32'(i * 32'h01010101);
        repeat (3) @(negedge clk);
        chk(xfer_ready == 0, "R1", "ready after reset", xfer_ready, 0);
        chk(mem_req == 0, "R1", "req after reset", mem_req, 0);
        chk(reg_rdata == 0, "R1", "status after reset", reg_rdata, 0);
        rst_n = 1'b1;

        // word store block of three (R7, R5)
        lat = 1;
        wr(0, 32'h10); wr(1, 32'hA1B2C3D4); wr(2, csr(2, 1, 3));
        wait_ready(); wr(1, 32'h11112222);
        wait_ready(); wr(1, 32'h33334444);
        wait_ready();
        chk(mem_arr[4] == 32'hA1B2C3D4, "R7", "store word0", mem_arr[4], 32'hA1B2C3D4);
        chk(mem_arr[5] == 32'h11112222, "R7", "store word1", mem_arr[5], 32'h11112222);
        chk(mem_arr[6] == 32'h33334444, "R7", "store word2", mem_arr[6], 32'h33334444);
        peek(2, v);
        chk(v[18:16] == 3'b001, "R8", "done status", v[18:16], 1);
        peek(0, v);
        chk(v == 32'h1C, "R5", "word step address", v, 32'h1C);

        // word load block of three (R6)
        lat = 0;
        wr(0, 32'h10); wr(2, csr(2, 0, 3));
        for (int i = 0; i < 3; i++) begin
            wait_ready(); rd_data(v);
            chk(v == mem_arr[4+i], "R6", "load word", v, mem_arr[4+i]);
        end
        chk(xfer_ready == 1, "R8", "ready held after last load", xfer_ready, 1);

        // byte loads at odd address (R5, R6)
        mem_arr[8] = 32'h88776655;
        wr(0, 32'h21); wr(2, csr(0, 0, 2));
        wait_ready(); rd_data(v);
        chk(v == 32'h66, "R6", "byte load zero-extended", v, 32'h66);
        wait_ready(); rd_data(v);
        chk(v == 32'h77, "R6", "second byte", v, 32'h77);
        peek(0, v);
        chk(v == 32'h23, "R5", "byte step address", v, 32'h23);

        // halfword store (R5)
        lat = 2;
        mem_arr[9] = 32'h12345678;
        wr(0, 32'h26); wr(1, 32'hFFFFBEEF); wr(2, csr(1, 1, 1));
        wait_ready();
        chk(mem_arr[9] == 32'hBEEF5678, "R5", "halfword store lanes", mem_arr[9], 32'hBEEF5678);
        peek(0, v);
        chk(v == 32'h28, "R5", "half step address", v, 32'h28);

        // illegal size (R4)
        wr(2, csr(3, 0, 2));
        begin
            int reqs = 0;
            repeat (4) begin @(negedge clk); if (mem_req) reqs++; end
            chk(reqs == 0, "R4", "no request on bad size", reqs, 0);
        end
        peek(2, v);
        chk(v[18:16] == 3'b010, "R4", "error bit, idle", v[18:16], 3'b010);

        // count zero (R11)
        wr(2, csr(2, 0, 0));
        peek(2, v);
        chk(v[18:16] == 3'b001, "R11", "zero count completes", v[18:16], 3'b001);

        // writes while busy are ignored (R10)
        lat = 0;
        wr(0, 32'h10); wr(2, csr(2, 0, 2));
        wait_ready();
        wr(0, 32'h80); wr(2, csr(0, 1, 5));
        peek(2, v);
        chk(v[15:0] == 16'h0202, "R10", "csr unchanged while busy", v[15:0], 16'h0202);
        peek(0, v);
        chk(v == 32'h10, "R10", "address unchanged while busy", v, 32'h10);
        rd_data(v);
        wait_ready(); rd_data(v);
        chk(v == mem_arr[5], "R10", "sequence continued", v, mem_arr[5]);

        // bus error aborts (R9)
        lat = 2;
        err_serial = txn_no + 1;
        wr(0, 32'h10); wr(2, csr(2, 0, 3));
        wait_ready(); rd_data(v);
        repeat (10) @(negedge clk);
        chk(xfer_ready == 0, "R9", "ready low after error", xfer_ready, 0);
        peek(2, v);
        chk(v[18:16] == 3'b010, "R9", "error set, idle", v[18:16], 3'b010);
        chk(v[15:8] == 8'd2, "R9", "count frozen", v[15:8], 2);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule